// File: doc/BRIEF.md
# Interrupt Routing Table Register Block

This block holds the routing table of a pin-based interrupt router and gives software access to it through a pair of registers on a simple memory-mapped bus. Software first writes a select register to choose an internal register. It then reads or writes that register through a data window. The internal registers are a version word, an identifier and, for each input pin, a 64-bit routing entry. Each entry is reached as two 32-bit halves.

The full table is held in flops, and every field of every entry is driven out in parallel to the dispatch logic. The fields are vector, delivery mode, destination mode, polarity, trigger mode, mask, destination and a remote-pending flag. The dispatch logic can set or clear each pin's remote-pending flag through dedicated inputs. The block pulses a strobe when a bus write flips a mask bit and a strobe when an entry is rewritten. A write to an end-of-interrupt register is passed on as a vector strobe. Interrupt delivery and pending-request tracking belong to the dispatch logic.

Bus requests are single-cycle. A claimed request is answered one cycle later with `rsp_valid` and registered read data.

Top module: `irq_route_regs`

## Requirements
- R1: After synchronous reset, the select register reads 0, the identifier reads 0, every entry has mask = 1 and all other entry bits 0, and no strobe is active.
- R2: A write at offset 0x00 stores only bits 7:0 of the write data into the select register. A read at offset 0x00 returns the stored value zero-extended.
- R3: With select 0x01, the window reads {8'h00, NPINS-1, 8'h00, VER_CODE}, which is 32'h0017_0011 for the defaults. Window writes with select 0x01 change nothing.
- R4: With select 0x00, a window write stores data bits 27:24 as the identifier. Window reads with select 0x00 or 0x02 return the identifier in bits 27:24 and zero elsewhere. Window writes with select 0x02 change nothing.
- R5: For select ≥ 0x10, the entry index is (select − 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. Window reads return that half.
- R6: A window write to an entry's lower half clears its remote-pending flag (bit 14), whatever the written bit 14 is. An upper-half write leaves the flag alone. When not written that cycle, the flag is cleared by `rpend_clr` and otherwise set by `rpend_set`.
- R7: Window writes whose entry index is ≥ NPINS change nothing and raise no strobe. Window reads of such an index, or of any select value from 0x03 to 0x0F, return 0.
- R8: When a lower-half write changes an entry's mask bit, `mask_ntf_valid` is high for exactly the next cycle, with the pin index and the new mask value. A write that keeps the mask raises no such strobe.
- R9: Every in-range entry write, of either half, pulses `upd_valid` for one cycle with the pin index.
- R10: A write at offset 0x40 pulses `eoi_valid` for one cycle, with write-data bits 7:0 on `eoi_vector`.
- R11: A request is claimed, with `rsp_valid` high in the next cycle, only if its address lies in [BASE_ADDR, BASE_ADDR+SPAN) and is 16-byte aligned. A read at offset 0x10 returns the window. Reads at other claimed offsets, and all writes, return 0 on `rsp_rdata`.
- R12: The entry fields are driven on the per-pin outputs from this layout: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote-pending [14], trigger mode [15], mask [16], destination [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Request claimed (one cycle after request) |
| rsp_rdata | output | 32 | Read data |
| rpend_set | input | NPINS | Set remote-pending flag per pin |
| rpend_clr | input | NPINS | Clear remote-pending flag per pin |
| ent_vector | output | NPINS*8 | Vector per pin |
| ent_dlv | output | NPINS*3 | Delivery mode per pin |
| ent_dstmode | output | NPINS | Destination mode per pin |
| ent_pol | output | NPINS | Polarity per pin |
| ent_rpend | output | NPINS | Remote-pending flag per pin |
| ent_trig | output | NPINS | Trigger mode per pin |
| ent_mask | output | NPINS | Mask per pin |
| ent_dest | output | NPINS*8 | Destination per pin |
| mask_ntf_valid | output | 1 | Mask bit changed |
| mask_ntf_pin | output | IDX_W | Pin whose mask changed |
| mask_ntf_val | output | 1 | New mask value |
| upd_valid | output | 1 | Entry rewritten |
| upd_pin | output | IDX_W | Pin whose entry was rewritten |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | End-of-interrupt vector |

## Verification
The window is exercised with three kinds of select value:
- The fixed selectors 0x00, 0x01 and 0x02. These tell the writable identifier apart from the read-only version word and the read-only alias.
- An even/odd pair for a middle pin. This shows that the half selection and the field layout land in the right bits.
- The last legal entry (0x3E) and the first illegal one (0x40). These separate an off-by-one in the index bound from a correct discard.

Remote-pending is driven with sets, clears, and lower and upper writes with bit 14 set, so the write-side clear can be told apart from a plain data write. The mask strobe is tried with a write that keeps the mask and with writes that flip it each way. Addresses that are unaligned, below the range, at its end and inside it test the claim logic.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // fixed window selectors
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  // entry field positions
  localparam int F_VEC   = 0;
  localparam int F_DLV   = 8;
  localparam int F_DSTM  = 11;
  localparam int F_POL   = 13;
  localparam int F_RPEND = 14;
  localparam int F_TRIG  = 15;
  localparam int F_MASK  = 16;
  localparam int F_DEST  = 56;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SEL,
    ACC_WIN,
    ACC_EOI,
    ACC_OTHER
  } acc_e;
endpackage

// File: rtl/irq_route_addr_dec.sv
module irq_route_addr_dec
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFEC0_0000,
  parameter logic [ADDR_W-1:0] SPAN = 32'h100,
  parameter logic [ADDR_W-1:0] OFS_SEL = 32'h00,
  parameter logic [ADDR_W-1:0] OFS_WIN = 32'h10,
  parameter logic [ADDR_W-1:0] OFS_EOI = 32'h40
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_e              kind
);
  logic [ADDR_W-1:0] offset;
  logic in_range, aligned;

  always_comb begin
    offset   = addr - BASE_ADDR;
    in_range = (addr >= BASE_ADDR) && (offset < SPAN);
    aligned  = (offset[3:0] == 4'h0);
    if (!in_range || !aligned)  kind = ACC_NONE;
    else if (offset == OFS_SEL) kind = ACC_SEL;
    else if (offset == OFS_WIN) kind = ACC_WIN;
    else if (offset == OFS_EOI) kind = ACC_EOI;
    else                        kind = ACC_OTHER;
  end
endmodule

// File: rtl/irq_route_sel_dec.sv
module irq_route_sel_dec
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       sel,
  output logic             is_tbl,
  output logic             idx_ok,
  output logic             hi,
  output logic [IDX_W-1:0] idx
);
  logic [7:0] rel;
  logic [6:0] raw;

  always_comb begin
    rel    = sel - SEL_TBL;
    raw    = rel[7:1];
    is_tbl = (sel >= SEL_TBL);
    hi     = sel[0];
    idx    = IDX_W'(raw);
    idx_ok = is_tbl && (int'(raw) < NPINS);
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [31:0]         wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_hi,
  output logic [31:0]         rd_data,
  input  logic [NPINS-1:0]    rpend_set,
  input  logic [NPINS-1:0]    rpend_clr,
  output logic [NPINS*64-1:0] tbl_flat,
  output logic                ntf_valid,
  output logic [IDX_W-1:0]    ntf_pin,
  output logic                ntf_mask,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_pin
);
  localparam logic [63:0] RST_ENT = 64'(1) << F_MASK;

  logic [63:0]      ent_arr [NPINS];
  logic [NPINS-1:0] mask_vec;
  logic [NPINS-1:0] rpend_vec;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [63:0] ent_q;
    logic        hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= RST_ENT;
      end else begin
        if (hit && wr_hi) begin
          ent_q[63:32] <= wr_data;
        end
        if (hit && !wr_hi) begin
          ent_q[31:0]     <= wr_data;
          ent_q[F_RPEND]  <= 1'b0;
        end else if (rpend_clr[g]) begin
          ent_q[F_RPEND]  <= 1'b0;
        end else if (rpend_set[g]) begin
          ent_q[F_RPEND]  <= 1'b1;
        end
      end
    end

    assign ent_arr[g]           = ent_q;
    assign tbl_flat[g*64 +: 64] = ent_q;
    assign mask_vec[g]          = ent_q[F_MASK];
    assign rpend_vec[g]         = ent_q[F_RPEND];
  end

  always_comb begin
    rd_data = rd_hi ? ent_arr[rd_idx][63:32] : ent_arr[rd_idx][31:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ntf_valid <= 1'b0;
      ntf_pin   <= '0;
      ntf_mask  <= 1'b0;
      upd_valid <= 1'b0;
      upd_pin   <= '0;
    end else begin
      ntf_valid <= wr_en && !wr_hi && (wr_data[F_MASK] != mask_vec[wr_idx]);
      ntf_pin   <= wr_idx;
      ntf_mask  <= wr_data[F_MASK];
      upd_valid <= wr_en;
      upd_pin   <= wr_idx;
    end
  end

  // R6: a lower-half write leaves the flag low in the next cycle
  p_rpend_wrclr_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi) |=> !rpend_vec[$past(wr_idx)]);

  // R8: mask bits move only together with a notify strobe
  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mask_vec) |-> ntf_valid);

  // R8: the notify strobe carries the value the entry now holds
  p_ntf_value_r8: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> (mask_vec[ntf_pin] == ntf_mask));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFEC0_0000,
  parameter logic [ADDR_W-1:0] SPAN = 32'h100,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                req_wr,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NPINS-1:0]    rpend_set,
  input  logic [NPINS-1:0]    rpend_clr,
  output logic [NPINS*8-1:0]  ent_vector,
  output logic [NPINS*3-1:0]  ent_dlv,
  output logic [NPINS-1:0]    ent_dstmode,
  output logic [NPINS-1:0]    ent_pol,
  output logic [NPINS-1:0]    ent_rpend,
  output logic [NPINS-1:0]    ent_trig,
  output logic [NPINS-1:0]    ent_mask,
  output logic [NPINS*8-1:0]  ent_dest,
  output logic                mask_ntf_valid,
  output logic [IDX_W-1:0]    mask_ntf_pin,
  output logic                mask_ntf_val,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_pin,
  output logic                eoi_valid,
  output logic [7:0]          eoi_vector
);
  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  acc_e kind;
  logic [7:0] sel_q;
  logic [3:0] id_q;
  logic is_tbl, idx_ok, sel_hi;
  logic [IDX_W-1:0] sel_idx;
  logic [31:0] tbl_rd, win_val, rd_mux;
  logic [NPINS*64-1:0] tbl_flat;
  logic wr_req, win_wr, tbl_wr;

  irq_route_addr_dec #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SPAN(SPAN),
    .OFS_SEL(ADDR_W'(32'h00)), .OFS_WIN(ADDR_W'(32'h10)), .OFS_EOI(ADDR_W'(32'h40))
  ) u_adec (
    .addr(req_addr),
    .kind(kind)
  );

  irq_route_sel_dec #(.NPINS(NPINS), .IDX_W(IDX_W)) u_sdec (
    .sel(sel_q),
    .is_tbl(is_tbl),
    .idx_ok(idx_ok),
    .hi(sel_hi),
    .idx(sel_idx)
  );

  assign wr_req = req && req_wr;
  assign win_wr = wr_req && (kind == ACC_WIN);
  assign tbl_wr = win_wr && idx_ok;

  irq_route_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk),
    .rst(rst),
    .wr_en(tbl_wr),
    .wr_hi(sel_hi),
    .wr_idx(sel_idx),
    .wr_data(req_wdata),
    .rd_idx(sel_idx),
    .rd_hi(sel_hi),
    .rd_data(tbl_rd),
    .rpend_set(rpend_set),
    .rpend_clr(rpend_clr),
    .tbl_flat(tbl_flat),
    .ntf_valid(mask_ntf_valid),
    .ntf_pin(mask_ntf_pin),
    .ntf_mask(mask_ntf_val),
    .upd_valid(upd_valid),
    .upd_pin(upd_pin)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign ent_vector[g*8 +: 8] = tbl_flat[g*64 + F_VEC  +: 8];
    assign ent_dlv[g*3 +: 3]    = tbl_flat[g*64 + F_DLV  +: 3];
    assign ent_dstmode[g]       = tbl_flat[g*64 + F_DSTM];
    assign ent_pol[g]           = tbl_flat[g*64 + F_POL];
    assign ent_rpend[g]         = tbl_flat[g*64 + F_RPEND];
    assign ent_trig[g]          = tbl_flat[g*64 + F_TRIG];
    assign ent_mask[g]          = tbl_flat[g*64 + F_MASK];
    assign ent_dest[g*8 +: 8]   = tbl_flat[g*64 + F_DEST +: 8];
  end

  always_comb begin
    if (is_tbl) begin
      win_val = idx_ok ? tbl_rd : 32'h0;
    end else begin
      case (sel_q)
        SEL_ID, SEL_ARB: win_val = {4'h0, id_q, 24'h0};
        SEL_VER:         win_val = {8'h00, MAX_PIN, 8'h00, VER_CODE};
        default:         win_val = 32'h0;
      endcase
    end
    case (kind)
      ACC_SEL: rd_mux = {24'h0, sel_q};
      ACC_WIN: rd_mux = win_val;
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 8'h00;
      id_q       <= 4'h0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 32'h0;
      eoi_valid  <= 1'b0;
      eoi_vector <= 8'h00;
    end else begin
      if (wr_req && kind == ACC_SEL) sel_q <= req_wdata[7:0];
      if (win_wr && sel_q == SEL_ID) id_q  <= req_wdata[27:24];
      rsp_valid  <= req && (kind != ACC_NONE);
      rsp_rdata  <= (req && !req_wr) ? rd_mux : 32'h0;
      eoi_valid  <= wr_req && (kind == ACC_EOI);
      eoi_vector <= req_wdata[7:0];
    end
  end

  // R1: state left by reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&ent_mask) && (sel_q == 8'h00) && !mask_ntf_valid && !eoi_valid));

  // R2: the select register keeps the low byte of the write
  p_sel_low8_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && kind == ACC_SEL) |=> (sel_q == $past(req_wdata[7:0])));

  // R7: writes past the table raise no update strobe
  p_discard_r7: assert property (@(posedge clk) disable iff (rst)
    (win_wr && is_tbl && !idx_ok) |=> !upd_valid);

  // R10: the end-of-interrupt strobe follows a write to its offset
  p_eoi_src_r10: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> $past(wr_req && kind == ACC_EOI));

  // R11: unclaimed requests get no response
  p_no_claim_r11: assert property (@(posedge clk) disable iff (rst)
    (req && kind == ACC_NONE) |=> !rsp_valid);

  // R11: a response always answers a request
  p_rsp_src_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req));
endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;
  localparam int NPINS = 24;
  localparam int IDX_W = 5;
  localparam logic [31:0] BASE = 32'hFEC0_0000;
  localparam logic [31:0] A_SEL = BASE + 32'h00;
  localparam logic [31:0] A_WIN = BASE + 32'h10;
  localparam logic [31:0] A_EOI = BASE + 32'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NPINS-1:0] rpend_set = '0, rpend_clr = '0;
  logic [NPINS*8-1:0] ent_vector, ent_dest;
  logic [NPINS*3-1:0] ent_dlv;
  logic [NPINS-1:0] ent_dstmode, ent_pol, ent_rpend, ent_trig, ent_mask;
  logic mask_ntf_valid, mask_ntf_val, upd_valid, eoi_valid;
  logic [IDX_W-1:0] mask_ntf_pin, upd_pin;
  logic [7:0] eoi_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_regs u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rpend_set(rpend_set), .rpend_clr(rpend_clr),
    .ent_vector(ent_vector), .ent_dlv(ent_dlv), .ent_dstmode(ent_dstmode),
    .ent_pol(ent_pol), .ent_rpend(ent_rpend), .ent_trig(ent_trig),
    .ent_mask(ent_mask), .ent_dest(ent_dest),
    .mask_ntf_valid(mask_ntf_valid), .mask_ntf_pin(mask_ntf_pin),
    .mask_ntf_val(mask_ntf_val), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns at the negedge after the capturing edge
  task automatic bus(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                     output logic [31:0] rdata, output logic vld);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req = 1'b0; req_wr = 1'b0;
    rdata = rsp_rdata; vld = rsp_valid;
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] data);
    logic [31:0] d; logic v;
    bus(1'b1, addr, data, d, v);
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] data);
    logic v;
    bus(1'b0, addr, 32'h0, data, v);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 mask all set", 32'(ent_mask), 32'h00FF_FFFF);
    check("R1 vectors zero", 32'(ent_vector[31:0]), 32'h0);
    check("R1 strobes idle", {29'h0, mask_ntf_valid, upd_valid, eoi_valid}, 32'h0);
    rd(A_SEL, d);
    check("R1 select zero", d, 32'h0);
    rd(A_WIN, d);
    check("R1 id zero", d, 32'h0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(A_SEL, 32'h0000_ABA5);
    rd(A_SEL, d);
    check("R2 select low byte", d, 32'h0000_00A5);
  endtask

  task automatic t_version();
    logic [31:0] d;
    wr(A_SEL, 32'h01);
    rd(A_WIN, d);
    check("R3 version word", d, 32'h0017_0011);
    wr(A_WIN, 32'hFFFF_FFFF);
    rd(A_WIN, d);
    check("R3 version ignores write", d, 32'h0017_0011);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    wr(A_SEL, 32'h00);
    wr(A_WIN, 32'h5A00_FFFF);
    rd(A_WIN, d);
    check("R4 id readback", d, 32'h0A00_0000);
    wr(A_SEL, 32'h02);
    rd(A_WIN, d);
    check("R4 arb alias", d, 32'h0A00_0000);
    wr(A_WIN, 32'h0300_0000);
    wr(A_SEL, 32'h00);
    rd(A_WIN, d);
    check("R4 arb write ignored", d, 32'h0A00_0000);
    wr(A_SEL, 32'h05);
    rd(A_WIN, d);
    check("R7 unused selector reads zero", d, 32'h0);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    wr(A_SEL, 32'h1A);
    wr(A_WIN, 32'h0000_A9C7);
    check("R8 notify on unmask", {26'h0, mask_ntf_valid, mask_ntf_pin, mask_ntf_val}, {26'h0, 1'b1, 5'd5, 1'b0});
    check("R9 update strobe lower", {26'h0, upd_valid, upd_pin}, {26'h0, 1'b1, 5'd5});
    wr(A_SEL, 32'h1B);
    wr(A_WIN, 32'h3C00_0000);
    check("R9 update strobe upper", {26'h0, upd_valid, upd_pin}, {26'h0, 1'b1, 5'd5});
    check("R8 no notify on upper", {31'h0, mask_ntf_valid}, 32'h0);
    rd(A_WIN, d);
    check("R5 upper half readback", d, 32'h3C00_0000);
    wr(A_SEL, 32'h1A);
    rd(A_WIN, d);
    check("R5 lower half readback", d, 32'h0000_A9C7);
    check("R12 fields pin5",
          {ent_vector[5*8 +: 8], ent_dest[5*8 +: 8], 5'h0, ent_dlv[5*3 +: 3],
           2'b0, ent_dstmode[5], ent_pol[5], ent_trig[5], ent_mask[5], ent_rpend[5], 1'b0},
          {8'hC7, 8'h3C, 8'h01, 8'b0011_1000});
    wr(A_SEL, 32'h3E);
    wr(A_WIN, 32'h0001_0040);
    check("R5 last pin index", {26'h0, upd_valid, upd_pin}, {26'h0, 1'b1, 5'd23});
    check("R12 vector pin23", 32'(ent_vector[23*8 +: 8]), 32'h40);
  endtask

  task automatic t_rpend();
    logic [31:0] d;
    @(negedge clk); rpend_set[5] = 1'b1;
    @(negedge clk); rpend_set[5] = 1'b0;
    check("R6 set flag", 32'(ent_rpend[5]), 32'h1);
    wr(A_SEL, 32'h1A);
    rd(A_WIN, d);
    check("R6 flag in bit14", d, 32'h0000_E9C7);
    wr(A_SEL, 32'h1B);
    wr(A_WIN, 32'h3D00_4000);
    check("R6 upper write keeps flag", 32'(ent_rpend[5]), 32'h1);
    wr(A_SEL, 32'h1A);
    wr(A_WIN, 32'h0000_E9C7);
    check("R6 lower write clears flag", 32'(ent_rpend[5]), 32'h0);
    check("R8 same mask no notify", {31'h0, mask_ntf_valid}, 32'h0);
    rd(A_WIN, d);
    check("R6 readback after clear", d, 32'h0000_A9C7);
    @(negedge clk); rpend_set[7] = 1'b1;
    @(negedge clk); rpend_set[7] = 1'b0; rpend_clr[7] = 1'b1;
    @(negedge clk); rpend_clr[7] = 1'b0;
    check("R6 clear input", 32'(ent_rpend[7]), 32'h0);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    wr(A_SEL, 32'h40);
    wr(A_WIN, 32'hFFFF_FFFF);
    check("R7 no strobe beyond table", {30'h0, upd_valid, mask_ntf_valid}, 32'h0);
    rd(A_WIN, d);
    check("R7 read beyond table", d, 32'h0);
    wr(A_SEL, 32'h3E);
    rd(A_WIN, d);
    check("R7 last entry untouched", d, 32'h0001_0040);
    wr(A_SEL, 32'hFF);
    rd(A_WIN, d);
    check("R7 top selector reads zero", d, 32'h0);
  endtask

  task automatic t_mask();
    wr(A_SEL, 32'h3E);
    wr(A_WIN, 32'h0000_0040);
    check("R8 unmask pin23", {26'h0, mask_ntf_valid, mask_ntf_pin, mask_ntf_val}, {26'h0, 1'b1, 5'd23, 1'b0});
    @(negedge clk);
    check("R8 strobe one cycle", {31'h0, mask_ntf_valid}, 32'h0);
    wr(A_WIN, 32'h0001_0040);
    check("R8 remask pin23", {26'h0, mask_ntf_valid, mask_ntf_pin, mask_ntf_val}, {26'h0, 1'b1, 5'd23, 1'b1});
    check("R8 mask output", 32'(ent_mask[23]), 32'h1);
  endtask

  task automatic t_eoi();
    wr(A_EOI, 32'h1234_5677);
    check("R10 eoi strobe", {23'h0, eoi_valid, eoi_vector}, {23'h0, 1'b1, 8'h77});
    @(negedge clk);
    check("R10 eoi one cycle", {31'h0, eoi_valid}, 32'h0);
  endtask

  task automatic t_claim();
    logic [31:0] d; logic v;
    bus(1'b0, BASE + 32'h08, 32'h0, d, v);
    check("R11 unaligned not claimed", {31'h0, v}, 32'h0);
    bus(1'b0, BASE + 32'h100, 32'h0, d, v);
    check("R11 past end not claimed", {31'h0, v}, 32'h0);
    bus(1'b0, BASE - 32'h10, 32'h0, d, v);
    check("R11 below base not claimed", {31'h0, v}, 32'h0);
    bus(1'b0, BASE + 32'h20, 32'h0, d, v);
    check("R11 other offset claimed zero", {v, d[30:0]}, 32'h8000_0000);
    bus(1'b1, A_WIN, 32'h0000_0040, d, v);
    check("R11 write claimed zero data", {v, d[30:0]}, 32'h8000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_version();
    t_ident();
    t_entry();
    t_rpend();
    t_oob();
    t_mask();
    t_eoi();
    t_claim();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule